// File: doc/BRIEF.md
# Montgomery Modular Exponentiator

This block raises a K-bit base to an EW-bit power modulo an odd K-bit modulus. It uses only Montgomery products. The caller supplies the base, the exponent, the modulus and the constant 2^(2K) mod modulus, then pulses `start` for one cycle. The unit returns the reduced result on `y_out` and marks it with a one-cycle `done` pulse.

Each product is done in radix 2 over K iterations. On each iteration the multiplier adds one multiplicand bit times the other operand, adds the modulus when that sum is odd, and halves. The running sum is kept as a sum/carry pair, so no carry has to ripple through any iteration. After the last iteration one extra cycle resolves the pair with a single adder and subtracts the modulus once if needed. That cycle also starts the next product.

The controller works through a fixed list of products:
- It converts the base into the Montgomery domain.
- It forms the Montgomery form of one, which is 2^K mod M.
- It scans the exponent from its top bit down, squaring on every bit and multiplying by the converted base when the bit is set.
- It converts the result back with a product by one.

Top module: `montexp`

## Requirements
- R1: After reset, `busy`, `done` and `y_out` are all 0.
- R2: For any odd modulus M, any K-bit base X (including X >= M) and any EW-bit exponent E, the result is X^E mod M. The precomputed input must equal 2^(2K) mod M.
- R3: When E is 0, the result is 1 mod M. That is 1, or 0 when M is 1.
- R4: `done` rises exactly (3 + EW + popcount(E)) * (K + 1) clock edges after the edge that captured `start`.
- R5: `done` is high for exactly one cycle. `y_out` keeps its value until the next `done`.
- R6: A `start` pulse while `busy` is high is ignored. The operation in flight keeps its result and its latency.
- R7: `busy` goes high on the edge that captures `start` and is low again in the cycle that `done` is high.
- R8: Every result is fully reduced: `y_out` < M.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an exponentiation; sampled only when idle |
| x_in | input | K | Base X |
| e_in | input | EW | Exponent E, scanned from bit EW-1 down |
| m_in | input | K | Odd modulus M |
| r2_in | input | K | Precomputed 2^(2K) mod M |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: `y_out` is valid |
| y_out | output | K | Result X^E mod M |

## Verification
Each result is due a fixed number of edges after the start edge. That number is K+1 for every Montgomery product, times 3 + EW + popcount(E) products. The bench predicts it from the exponent alone. Inputs are driven and outputs sampled on falling edges. From the start edge, the bench counts falling edges until `done` is seen, and compares both the count and the value. It then waits a few more cycles and checks that `done` has dropped and `y_out` has held.

// File: rtl/montexp.sv
module montexp #(
  parameter int K  = 64,
  parameter int EW = K
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [K-1:0]  x_in,
  input  logic [EW-1:0] e_in,
  input  logic [K-1:0]  m_in,
  input  logic [K-1:0]  r2_in,
  output logic          busy,
  output logic          done,
  output logic [K-1:0]  y_out
);
  localparam int W  = K + 2;
  localparam int CW = $clog2(K + 1);
  localparam int IW = (EW > 1) ? $clog2(EW) : 1;

  typedef enum logic [2:0] {S_IDLE, S_CVX, S_INI, S_SQR, S_MUL, S_OUT} st_t;

  st_t            st;
  logic [K-1:0]   xm_q, m_q, r2_q, a_q, b_q, y_q;
  logic [EW-1:0]  e_q;
  logic [W-1:0]   s_q, c_q;
  logic [CW-1:0]  cnt_q;
  logic [IW-1:0]  idx_q;
  logic           done_q;

  wire [W-1:0] ab  = a_q[0] ? {2'b00, b_q} : '0;
  wire [W-1:0] s1  = s_q ^ c_q ^ ab;
  wire [W-1:0] c1  = ((s_q & c_q) | (s_q & ab) | (c_q & ab)) << 1;
  wire [W-1:0] mq  = s1[0] ? {2'b00, m_q} : '0;
  wire [W-1:0] s2  = s1 ^ c1 ^ mq;
  wire [W-1:0] c2  = ((s1 & c1) | (s1 & mq) | (c1 & mq)) << 1;
  wire [W-1:0] s_n = s2 >> 1;
  wire [W-1:0] c_n = c2 >> 1;

  wire [W-1:0] sum_w  = s_q + c_q;
  wire [W-1:0] diff_w = sum_w - {2'b00, m_q};
  wire [K-1:0] res    = diff_w[W-1] ? sum_w[K-1:0] : diff_w[K-1:0];
  wire         last   = (cnt_q == CW'(K));

  assign busy  = (st != S_IDLE);
  assign done  = done_q;
  assign y_out = y_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      xm_q   <= '0;
      m_q    <= '0;
      r2_q   <= '0;
      a_q    <= '0;
      b_q    <= '0;
      y_q    <= '0;
      e_q    <= '0;
      s_q    <= '0;
      c_q    <= '0;
      cnt_q  <= '0;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (st != S_IDLE && !last) begin
        s_q   <= s_n;
        c_q   <= c_n;
        a_q   <= a_q >> 1;
        cnt_q <= cnt_q + 1'b1;
      end
      case (st)
        S_IDLE: if (start) begin
          e_q   <= e_in;
          m_q   <= m_in;
          r2_q  <= r2_in;
          a_q   <= x_in;
          b_q   <= r2_in;
          s_q   <= '0;
          c_q   <= '0;
          cnt_q <= '0;
          st    <= S_CVX;
        end
        S_CVX: if (last) begin
          xm_q  <= res;
          a_q   <= K'(1);
          b_q   <= r2_q;
          s_q   <= '0;
          c_q   <= '0;
          cnt_q <= '0;
          st    <= S_INI;
        end
        S_INI: if (last) begin
          a_q   <= res;
          b_q   <= res;
          idx_q <= IW'(EW - 1);
          s_q   <= '0;
          c_q   <= '0;
          cnt_q <= '0;
          st    <= S_SQR;
        end
        S_SQR: if (last) begin
          s_q   <= '0;
          c_q   <= '0;
          cnt_q <= '0;
          a_q   <= res;
          if (e_q[idx_q]) begin
            b_q <= xm_q;
            st  <= S_MUL;
          end else if (idx_q == '0) begin
            b_q <= K'(1);
            st  <= S_OUT;
          end else begin
            b_q   <= res;
            idx_q <= idx_q - 1'b1;
            st    <= S_SQR;
          end
        end
        S_MUL: if (last) begin
          s_q   <= '0;
          c_q   <= '0;
          cnt_q <= '0;
          a_q   <= res;
          if (idx_q == '0) begin
            b_q <= K'(1);
            st  <= S_OUT;
          end else begin
            b_q   <= res;
            idx_q <= idx_q - 1'b1;
            st    <= S_SQR;
          end
        end
        S_OUT: if (last) begin
          y_q    <= res;
          done_q <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/montexp_chk.sv
module montexp_chk #(
  parameter int K = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [K-1:0] y_out,
  input logic [K-1:0] m_q
);
  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R5
  y_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(y_out));
  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  // R7
  start_take_chk: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy);
  // R8
  reduced_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> (y_out < m_q));
endmodule

bind montexp montexp_chk #(.K(K)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .done(done), .y_out(y_out), .m_q(m_q)
);

// File: tb/tb_montexp.sv
module tb_montexp;
  localparam int K  = 8;
  localparam int EW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [K-1:0]  x_in = '0;
  logic [EW-1:0] e_in = '0;
  logic [K-1:0]  m_in = '0;
  logic [K-1:0]  r2_in = '0;
  logic          busy, done;
  logic [K-1:0]  y_out;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  montexp #(.K(K), .EW(EW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .x_in(x_in), .e_in(e_in),
    .m_in(m_in), .r2_in(r2_in), .busy(busy), .done(done), .y_out(y_out)
  );

  function automatic int ref_pow(int x, int e, int m);
    longint r = 1 % m;
    longint b = x % m;
    for (int i = EW - 1; i >= 0; i--) begin
      r = (r * r) % m;
      if ((e >> i) & 1) r = (r * b) % m;
    end
    return int'(r);
  endfunction

  function automatic int lat(int e);
    return (3 + EW + $countones(e[EW-1:0])) * (K + 1);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // Runs one exponentiation; optional mid-flight start with other operands (R6).
  task automatic run(int x, int e, int m, bit poke, bit full);
    int n;
    int exp;
    int yv;
    exp = ref_pow(x, e, m);
    @(negedge clk);
    x_in = K'(x); e_in = EW'(e); m_in = K'(m);
    r2_in = K'((64'd1 << (2 * K)) % m);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    if (full) chk(busy, "R7 busy after start", int'(busy), 1);
    while (!done && n < 1000) begin
      if (poke && n == 20) begin
        x_in = ~x_in; e_in = ~e_in; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    if (e == 0) chk(y_out == K'(exp), "R3 zero exponent", int'(y_out), exp);
    else        chk(y_out == K'(exp), "R2 result", int'(y_out), exp);
    if (full || poke) begin
      chk(n == lat(e), poke ? "R6 latency with ignored start" : "R4 latency", n, lat(e));
      chk(!busy, "R7 busy low with done", int'(busy), 0);
      chk(y_out < K'(m), "R8 reduced", int'(y_out), m);
      yv = int'(y_out);
      @(negedge clk);
      chk(!done, "R5 single-cycle done", int'(done), 0);
      @(negedge clk);
      @(negedge clk);
      chk(int'(y_out) == yv, "R5 result held", int'(y_out), yv);
    end
  endtask

  initial begin
    #4000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    #35;
    chk(!busy, "R1 busy at reset", int'(busy), 0);
    chk(!done, "R1 done at reset", int'(done), 0);
    chk(y_out == '0, "R1 y at reset", int'(y_out), 0);
    rst_n = 1'b1;
    // full checks on a few cases
    run(5, 13, 7, 1'b0, 1'b1);
    run(200, 0, 251, 1'b0, 1'b1);
    run(3, 15, 1, 1'b0, 1'b1);
    run(255, 15, 255, 1'b0, 1'b1);
    // R6: start while busy
    run(17, 9, 101, 1'b1, 1'b0);
    // sweep moduli and exponents (R2, R3)
    for (int m = 1; m < 256; m += 6)
      for (int e = 0; e < 16; e++)
        run((m * 37 + e * 11) & 8'hff, e, m, 1'b0, 1'b0);
    // sweep all bases for one modulus (R2, including X >= M)
    for (int x = 0; x < 256; x++)
      run(x, 11, 239, 1'b0, 1'b0);
    summary();
  end
endmodule